// File: doc/BRIEF.md
# NAND Multi-Bank Chip-Select and Write-Strobe Interface

This block connects a CPU-side byte bus to as many as four external NAND banks. A single control register holds two bits per bank. The even bit (2n) opens bank n for use. The odd bit (2n+1) asserts that bank's chip. The active-low chip-enable pin of a bank goes low only while both of its bits are set.

A CPU byte write into a bank's memory window becomes one NAND bus cycle. The offset inside the window picks the role of the cycle: a command byte drives CLE, an address byte drives ALE, and any other offset is a data byte. The block then runs the write-enable strobe. The strobe stays low for a programmed number of clocks and is followed by a programmed hold. Only after that does the bus see ready.

A write into a bank whose enable bit is clear completes on the bus at once. It moves no NAND pin and sets a sticky error flag.

Top module: `nand_bank_if`

## Requirements
- R1: After reset the control register is 0, every `nand_ce_n` bit is 1, `nand_we_n` is 1, `nand_cle`, `nand_ale`, `bus_ready` and `bank_err` are 0.
- R2: A register-space write (`bus_space`=0) at address 0x50 loads `bus_wdata[7:0]` into the control register, which is visible on `ctrl_state`. A register-space write at any other address except 0x54 leaves the register unchanged.
- R3: `nand_ce_n[n]` is 0 exactly when control bit 2n (enable) and bit 2n+1 (assert) are both 1.
- R4: A register-space write at address 0x54 clears every odd (assert) bit at once and keeps every even (enable) bit.
- R5: Writing 0 to address 0x50 drives all `nand_ce_n` high and clears `ctrl_state`.
- R6: A memory write (`bus_space`=1) at window offset 0x08000 is a command cycle. `nand_cle` is 1 and `nand_ale` is 0 while the strobe is low.
- R7: A memory write at window offset 0x10000 is an address cycle. `nand_ale` is 1 and `nand_cle` is 0 while the strobe is low.
- R8: A memory write at any other window offset is a data cycle, with both `nand_cle` and `nand_ale` at 0.
- R9: `nand_cle` and `nand_ale` are never 1 in the same cycle.
- R10: For a memory write to an enabled bank, `nand_we_n` is low for max(`cfg_we_len`,1) clocks. It is then high for `cfg_hold_len` clocks before `bus_ready`, and `nand_io` carries the written byte throughout.
- R11: A memory write to a bank whose enable bit is 0 completes with `bus_ready` and never lowers `nand_we_n` or raises CLE or ALE. It sets `bank_err`, which stays 1 until reset.
- R12: Each accepted request gets `bus_ready` high for exactly one clock. The bank is `bus_addr[18:17]`, and the window offset is `bus_addr[16:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request present, held until bus_ready |
| bus_space | input | 1 | 0 = register space, 1 = bank memory |
| bus_addr | input | 19 | Register address, or {bank, window offset} |
| bus_wdata | input | 8 | Write byte |
| cfg_we_len | input | 4 | Strobe low length in clocks (0 treated as 1) |
| cfg_hold_len | input | 4 | Hold length after the strobe in clocks |
| bus_ready | output | 1 | One-clock completion pulse |
| ctrl_state | output | 8 | Current control register |
| nand_ce_n | output | 4 | Active-low chip enables, one per bank |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_io | output | 8 | Byte driven to the NAND bus |
| bank_err | output | 1 | Sticky flag for writes to disabled banks |

## Verification
A corrupted control register shows on `nand_ce_n` in the same cycle, because the pins are a pure function of its bits. A wrong deselect mask therefore leaves a chip asserted that should have been released. A wrong role decode shows as CLE or ALE at the wrong level on the first strobe clock of the cycle. A stuck counter in the strobe sequencer shows as a strobe or hold that is too long or too short, measured in whole clocks before `bus_ready` arrives. A lost error latch shows as `bank_err` dropping on the next request.

// File: rtl/nand_bank_pkg.sv
// Shared types for the NAND bank interface.
// Assumes at most four banks so the control register fits one bus byte.
package nand_bank_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        ROLE_DATA = 2'd0,
        ROLE_CMD  = 2'd1,
        ROLE_ADDR = 2'd2
    } byte_role_t;
endpackage

// File: rtl/nand_ctrl_reg.sv
// Control register: even bit = bank enable, odd bit = bank assert.
// Drives active-low chip enables. Assumes 2*NB <= DATA_W.
module nand_ctrl_reg #(
    parameter int NB         = 4,
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int CTRL_OFF   = 'h50,
    parameter int DESEL_OFF  = 'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [2*NB-1:0]   ctrl_q,
    output logic [NB-1:0]     ce_n
);
    localparam int CW = 2 * NB;

    logic [CW-1:0] assert_mask;

    // Build the mask of all odd (assert) bits.
    for (genvar b = 0; b < NB; b++) begin : g_mask
        assign assert_mask[2*b]   = 1'b0;
        assign assert_mask[2*b+1] = 1'b1;
    end

    // Register update: full load or collective deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_stb && wr_addr == ADDR_W'(CTRL_OFF)) begin
            ctrl_q <= wr_data[CW-1:0];
        end else if (wr_stb && wr_addr == ADDR_W'(DESEL_OFF)) begin
            ctrl_q <= ctrl_q & ~assert_mask;
        end
    end

    // A chip is selected only when both of its bits are set.
    for (genvar b = 0; b < NB; b++) begin : g_ce
        assign ce_n[b] = ~(ctrl_q[2*b] & ctrl_q[2*b+1]);
    end
endmodule

// File: rtl/nand_addr_decode.sv
// Splits a memory address into bank and window offset, classifies the
// byte role from the offset, and looks up the bank's enable bit.
module nand_addr_decode
    import nand_bank_pkg::*;
#(
    parameter int NB       = 4,
    parameter int WIN_W    = 17,
    parameter int CMD_OFF  = 'h08000,
    parameter int ADDR_OFF = 'h10000,
    parameter int BANK_W   = (NB > 1) ? $clog2(NB) : 1,
    parameter int ADDR_W   = WIN_W + BANK_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2*NB-1:0]   ctrl,
    output byte_role_t        role,
    output logic              bank_en
);
    logic [WIN_W-1:0]  offset;
    logic [BANK_W-1:0] bank;
    logic [NB-1:0]     en_vec;

    assign offset = addr[WIN_W-1:0];
    assign bank   = addr[ADDR_W-1:WIN_W];

    // Gather the enable bits into a per-bank vector.
    for (genvar b = 0; b < NB; b++) begin : g_en
        assign en_vec[b] = ctrl[2*b];
    end

    // Role from exact offset match; the two matches are exclusive.
    always_comb begin
        if (offset == WIN_W'(CMD_OFF))       role = ROLE_CMD;
        else if (offset == WIN_W'(ADDR_OFF)) role = ROLE_ADDR;
        else                                 role = ROLE_DATA;
    end

    // Enable lookup for the addressed bank.
    assign bank_en = en_vec[bank];
endmodule

// File: rtl/nand_we_seq.sv
// Per-request sequencer: accepts one bus request, runs strobe and hold
// for memory writes, and pulses ready once. Assumes bus_valid is held
// until ready is seen.
module nand_we_seq
    import nand_bank_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_space,
    input  logic              bank_en,
    input  byte_role_t        role_in,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LEN_W-1:0]  we_len,
    input  logic [LEN_W-1:0]  hold_len,
    output logic              reg_wr_stb,
    output logic              bus_ready,
    output logic              we_n,
    output logic              cle,
    output logic              ale,
    output logic [DATA_W-1:0] io,
    output logic              err_sticky
);
    seq_state_t       state;
    byte_role_t       role_q;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] hold_q;
    logic             accept;

    assign accept     = (state == ST_IDLE) && bus_valid;
    assign reg_wr_stb = accept && !bus_space;

    // State, counters and latched cycle attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            role_q     <= ROLE_DATA;
            cnt        <= '0;
            hold_q     <= '0;
            io         <= '0;
            err_sticky <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    if (!bus_space) begin
                        state <= ST_DONE;
                    end else if (bank_en) begin
                        state  <= ST_PULSE;
                        role_q <= role_in;
                        io     <= wdata;
                        cnt    <= (we_len == '0) ? LEN_W'(1) : we_len;
                        hold_q <= hold_len;
                    end else begin
                        err_sticky <= 1'b1;
                        state      <= ST_DONE;
                    end
                end
                ST_PULSE: begin
                    if (cnt == LEN_W'(1)) begin
                        cnt   <= hold_q;
                        state <= (hold_q == '0) ? ST_DONE : ST_HOLD;
                    end else begin
                        cnt <= cnt - LEN_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt == LEN_W'(1)) state <= ST_DONE;
                    else                  cnt   <= cnt - LEN_W'(1);
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pin drive derived from the registered state.
    always_comb begin
        we_n      = (state != ST_PULSE);
        cle       = (state == ST_PULSE || state == ST_HOLD) && role_q == ROLE_CMD;
        ale       = (state == ST_PULSE || state == ST_HOLD) && role_q == ROLE_ADDR;
        bus_ready = (state == ST_DONE);
    end
endmodule

// File: rtl/nand_bank_if.sv
// Top: CPU byte bus to multi-bank NAND chip-select, CLE/ALE and strobe.
// Assumes NB <= 4 and a power-of-two bank count.
module nand_bank_if
    import nand_bank_pkg::*;
#(
    parameter int NB       = 4,
    parameter int WIN_W    = 17,
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 4,
    parameter int BANK_W   = (NB > 1) ? $clog2(NB) : 1,
    parameter int ADDR_W   = WIN_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_space,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [LEN_W-1:0]  cfg_we_len,
    input  logic [LEN_W-1:0]  cfg_hold_len,
    output logic              bus_ready,
    output logic [2*NB-1:0]   ctrl_state,
    output logic [NB-1:0]     nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic [DATA_W-1:0] nand_io,
    output logic              bank_err
);
    byte_role_t role;
    logic       bank_en;
    logic       reg_wr_stb;

    nand_ctrl_reg #(.NB(NB), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (reg_wr_stb),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .ctrl_q  (ctrl_state),
        .ce_n    (nand_ce_n)
    );

    nand_addr_decode #(.NB(NB), .WIN_W(WIN_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .ctrl    (ctrl_state),
        .role    (role),
        .bank_en (bank_en)
    );

    nand_we_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_space  (bus_space),
        .bank_en    (bank_en),
        .role_in    (role),
        .wdata      (bus_wdata),
        .we_len     (cfg_we_len),
        .hold_len   (cfg_hold_len),
        .reg_wr_stb (reg_wr_stb),
        .bus_ready  (bus_ready),
        .we_n       (nand_we_n),
        .cle        (nand_cle),
        .ale        (nand_ale),
        .io         (nand_io),
        .err_sticky (bank_err)
    );
endmodule

// File: rtl/nand_bank_if_chk.sv
// Port-level checker for nand_bank_if, bound to every instance.
module nand_bank_if_chk #(
    parameter int NB     = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ready,
    input logic [2*NB-1:0]   ctrl_state,
    input logic [NB-1:0]     nand_ce_n,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic [DATA_W-1:0] nand_io,
    input logic              bank_err
);
    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R9
    AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_io) && $stable(nand_cle) && $stable(nand_ale))); // R10
    AST_NO_READY_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !bus_ready); // R10
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready); // R12
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bank_err |=> bank_err); // R11
    AST_ZERO_CTRL_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == '0) |-> (&nand_ce_n)); // R5
endmodule

bind nand_bank_if nand_bank_if_chk #(.NB(NB), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ready  (bus_ready),
    .ctrl_state (ctrl_state),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_io    (nand_io),
    .bank_err   (bank_err)
);

// File: tb/nand_bank_if_test.sv
// Directed bench: one task per scenario, each checking its own results.
module nand_bank_if_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_space = 1'b0;
    logic [18:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [3:0]  cfg_we_len = 4'd1;
    logic [3:0]  cfg_hold_len = 4'd0;
    logic        bus_ready;
    logic [7:0]  ctrl_state;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, bank_err;
    logic [7:0]  nand_io;

    int checks = 0;
    int errors = 0;
    int n_low, n_hold, n_ready_after;
    bit saw_cle, saw_ale, saw_both, io_ok;

    always #4 clk = ~clk;

    nand_bank_if uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_space(bus_space),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cfg_we_len(cfg_we_len),
        .cfg_hold_len(cfg_hold_len), .bus_ready(bus_ready), .ctrl_state(ctrl_state),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_io(nand_io), .bank_err(bank_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Run one request and record what the NAND pins did until ready.
    task automatic do_req(input bit space, input logic [18:0] addr, input logic [7:0] data,
                          input logic [3:0] wl, input logic [3:0] hl);
        bit done = 0;
        n_low = 0; n_hold = 0; n_ready_after = 0;
        saw_cle = 0; saw_ale = 0; saw_both = 0; io_ok = 1;
        @(negedge clk);
        bus_space = space; bus_addr = addr; bus_wdata = data;
        cfg_we_len = wl; cfg_hold_len = hl; bus_valid = 1'b1;
        while (!done) begin
            @(posedge clk);
            @(negedge clk);
            if (nand_cle && nand_ale) saw_both = 1;
            if (!nand_we_n) begin
                n_low++;
                if (nand_cle) saw_cle = 1;
                if (nand_ale) saw_ale = 1;
                if (nand_io != data) io_ok = 0;
            end else if (bus_ready) begin
                done = 1;
            end else if (n_low > 0) begin
                n_hold++;
                if (nand_io != data) io_ok = 0;
            end
        end
        bus_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        n_ready_after = bus_ready;
    endtask

    task automatic t_reset;
        check(ctrl_state == 8'h00, "R1 ctrl", ctrl_state, 0);
        check(nand_ce_n == 4'hF, "R1 ce_n", nand_ce_n, 4'hF);
        check(nand_we_n && !nand_cle && !nand_ale, "R1 pins",
              {nand_we_n, nand_cle, nand_ale}, 3'b100);
        check(!bus_ready && !bank_err, "R1 ready/err", {bus_ready, bank_err}, 0);
    endtask

    task automatic t_ctrl_load;
        do_req(0, 19'h50, 8'h07, 1, 0);
        check(ctrl_state == 8'h07, "R2 load", ctrl_state, 8'h07);
        check(nand_ce_n == 4'b1110, "R3 ce_n bank0 only", nand_ce_n, 4'b1110);
        check(n_ready_after == 0, "R12 single ready", n_ready_after, 0);
        do_req(0, 19'h58, 8'hFF, 1, 0);
        check(ctrl_state == 8'h07, "R2 other offset ignored", ctrl_state, 8'h07);
    endtask

    task automatic t_cmd;
        do_req(1, {2'd0, 17'h08000}, 8'h90, 3, 2);
        check(n_low == 3, "R10 strobe len", n_low, 3);
        check(n_hold == 2, "R10 hold len", n_hold, 2);
        check(io_ok, "R10 io byte", io_ok, 1);
        check(saw_cle && !saw_ale, "R6 command role", {saw_cle, saw_ale}, 2'b10);
        check(n_ready_after == 0, "R12 single ready", n_ready_after, 0);
    endtask

    task automatic t_addr;
        do_req(1, {2'd1, 17'h10000}, 8'h3C, 1, 0);
        check(n_low == 1 && n_hold == 0, "R10 short cycle", {n_low, n_hold}, 1);
        check(saw_ale && !saw_cle, "R7 address role", {saw_cle, saw_ale}, 2'b01);
    endtask

    task automatic t_data;
        do_req(1, {2'd0, 17'h00123}, 8'hA5, 0, 1);
        check(n_low == 1, "R10 zero length as one", n_low, 1);
        check(n_hold == 1, "R10 hold one", n_hold, 1);
        check(!saw_cle && !saw_ale, "R8 data role", {saw_cle, saw_ale}, 0);
        do_req(1, {2'd0, 17'h08001}, 8'h11, 2, 0);
        check(!saw_cle && !saw_ale, "R8 near-command offset", {saw_cle, saw_ale}, 0);
        check(!saw_both, "R9 exclusive", saw_both, 0);
    endtask

    task automatic t_disabled;
        do_req(1, {2'd2, 17'h08000}, 8'hFF, 3, 3);
        check(n_low == 0 && !saw_cle && !saw_ale, "R11 no pin activity",
              {n_low, saw_cle, saw_ale}, 0);
        check(bank_err, "R11 error set", bank_err, 1);
        do_req(1, {2'd0, 17'h00000}, 8'h01, 1, 0);
        check(bank_err, "R11 error sticky", bank_err, 1);
        check(n_low == 1, "R10 enabled still works", n_low, 1);
    endtask

    task automatic t_deselect;
        do_req(0, 19'h50, 8'hFF, 1, 0);
        check(nand_ce_n == 4'h0, "R3 all selected", nand_ce_n, 0);
        do_req(0, 19'h54, 8'h00, 1, 0);
        check(ctrl_state == 8'h55, "R4 asserts cleared", ctrl_state, 8'h55);
        check(nand_ce_n == 4'hF, "R4 ce_n released", nand_ce_n, 4'hF);
        do_req(0, 19'h50, 8'h0C, 1, 0);
        check(nand_ce_n == 4'b1101, "R3 bank1 only", nand_ce_n, 4'b1101);
        do_req(0, 19'h50, 8'h00, 1, 0);
        check(ctrl_state == 0 && nand_ce_n == 4'hF, "R5 zero write",
              {ctrl_state, nand_ce_n}, 4'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ctrl_load();
        t_cmd();
        t_addr();
        t_data();
        t_disabled();
        t_deselect();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule